// File: doc/BRIEF.md
# I2C Target with General-Call Decoding

This block is a two-wire serial bus target that sits behind a pair of open-drain pads. It oversamples the clock and data lines with the system clock. It finds START and STOP conditions and recognises its own 7-bit address. The address is built from a programmable upper part and a lower part that is taken from input pins. The target pulls the data line low through an enable output and never drives it high. Behind the address is a small register file. A location pointer selects the entry. In a write transfer, the first data byte loads the pointer. After that, each byte that is written or read moves the pointer on by one. The pointer keeps its value across a repeated START, so a write-then-read combined transfer can read back from any location.

The block also acts on the reserved addresses. Address byte 0x00 is the general call. Its second byte can select one of four actions:
- a full reset of the registers and the address;
- a reload of the pin-derived address part;
- a load of a new programmable address part from the byte that follows;
- a hardware call, whose following data byte is presented on an output with a one-cycle strobe.

The start byte is never acknowledged. The CBUS addresses put the target into a passive state until the next STOP. A busy input holds back the acknowledge while an internal write is still in progress.

Top module: `i2c_gc_target`

## Requirements
- R1: After reset, `sda_oe` and `hwcall_valid` are low. The own address is {PROG_RST, `hw_addr`}. An address byte whose bits 7:1 equal the own address is acknowledged: `sda_oe` is high during the ninth clock. Bit 0 selects the direction: 0 means the controller writes, 1 means it reads. `sda_oe` changes only after a falling SCL edge or a START or STOP condition.
- R2: An address byte that matches no known address is not acknowledged. The target then drives nothing, even across a repeated START, until the next STOP. After that STOP it responds to its address again.
- R3: A STOP at any point, including part-way through a byte, releases SDA and returns the target to waiting for START. A partial byte is not stored.
- R4: In a write transfer, the low log2(DEPTH) bits of the first data byte load the pointer. Each following byte is stored at the pointer and then moves the pointer on by one. The pointer wraps from DEPTH-1 to 0.
- R5: A read transfer returns the entry at the pointer, MSB first, and then moves the pointer on by one per byte. This continues from a pointer that was set before a repeated START.
- R6: In a read, if the controller leaves SDA high in the acknowledge slot, the target stops driving. A further byte clocked out reads as 0xFF. A repeated START with the own address in read direction then resumes from the pointer.
- R7: While `busy` is high at the end of an own-address byte or a data byte, that byte is not acknowledged. A data byte received under these conditions is not stored.
- R8: The general-call byte 0x00 is acknowledged when GC_EN is set. A second byte of 0x06 is acknowledged and clears every register entry to 0x00. It also restores the programmable part to PROG_RST and takes the pin part from `hw_addr` again.
- R9: A general-call second byte of 0x04 takes the pin part from `hw_addr` again and leaves the register contents unchanged.
- R10: A general-call second byte of 0x02 is acknowledged. Bits 7:(8-PROG_W) of the next byte become the programmable address part.
- R11: A general-call second byte with bit 0 set is acknowledged. For the next byte, `hwcall_data` shows that byte and `hwcall_src` shows bits 7:1 of the second byte, and `hwcall_valid` pulses high for exactly one cycle.
- R12: A general-call second byte of 0x00 is not acknowledged and changes nothing.
- R13: The start byte 0x01 is never acknowledged.
- R14: An address byte of 0x02 or 0x03 is not acknowledged. The target then ignores the bus, even its own address after a repeated START, until a STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Sampled bus clock line |
| sda_i | input | 1 | Sampled bus data line |
| sda_oe | output | 1 | Open-drain enable; high pulls SDA low |
| busy | input | 1 | Internal write in progress; withholds acknowledge |
| hw_addr | input | 7-PROG_W | Pin-derived low part of the own address |
| hwcall_src | output | 7 | Sender address of the last hardware call |
| hwcall_data | output | 8 | Data byte of the last hardware call |
| hwcall_valid | output | 1 | One-cycle strobe for a new hardware call |

## Verification
A wrong phase counter or state shows up at the ports within a single bus bit. It appears as an acknowledge in the wrong slot, a missing acknowledge, or SDA pulled low while the target should be silent. A pointer or address-register fault stays hidden until the next read or address byte. At that point it shows up as a wrong data byte or an acknowledge on the wrong address. For this reason each state change is followed by an address probe and a read-back. A full sweep of all 128 write addresses checks that the acknowledge appears only for the own address and the general call.

// File: rtl/i2c_gc_pkg.sv
package i2c_gc_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WDATA,
    ST_READ,
    ST_GCCMD,
    ST_GCPROG,
    ST_GCDATA,
    ST_HOLD,
    ST_WAITP
  } tgt_state_e;

  localparam logic [7:0] GC_ADDR_BYTE = 8'h00;
  localparam logic [7:0] START_BYTE   = 8'h01;
  localparam logic [6:0] CBUS_ADDR    = 7'h01;
  localparam logic [7:0] GC_FULL_RST  = 8'h06;
  localparam logic [7:0] GC_PIN_LOAD  = 8'h04;
  localparam logic [7:0] GC_NEW_PROG  = 8'h02;

endpackage

// File: rtl/i2c_gc_linemon.sv
module i2c_gc_linemon #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic rise,
  output logic fall,
  output logic start,
  output logic stop
);

  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_p, sda_p, scl_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_p  <= scl_sh[STAGES-1];
      sda_p  <= sda_sh[STAGES-1];
    end
  end

  assign scl_s = scl_sh[STAGES-1];
  assign sda_s = sda_sh[STAGES-1];
  assign rise  = scl_s & ~scl_p;
  assign fall  = ~scl_s & scl_p;
  assign start = scl_s & scl_p & sda_p & ~sda_s;
  assign stop  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/i2c_gc_regfile.sv
module i2c_gc_regfile #(
  parameter  int DEPTH = 16,
  parameter  int WIDTH = 8,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/i2c_gc_target.sv
module i2c_gc_target
  import i2c_gc_pkg::*;
#(
  parameter  int                DEPTH    = 16,
  parameter  int                PROG_W   = 4,
  parameter  logic [PROG_W-1:0] PROG_RST = 4'hA,
  parameter  bit                GC_EN    = 1'b1,
  parameter  int                SYNC     = 2,
  localparam int                HW_W     = 7 - PROG_W,
  localparam int                AW       = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            scl_i,
  input  logic            sda_i,
  output logic            sda_oe,
  input  logic            busy,
  input  logic [HW_W-1:0] hw_addr,
  output logic [6:0]      hwcall_src,
  output logic [7:0]      hwcall_data,
  output logic            hwcall_valid
);

  localparam logic [AW:0] CLR_END = (AW+1)'(DEPTH);

  logic l_sda, l_rise, l_fall, l_start, l_stop;

  i2c_gc_linemon #(.STAGES(SYNC)) u_mon (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(l_sda), .rise(l_rise), .fall(l_fall), .start(l_start), .stop(l_stop)
  );

  tgt_state_e        state, nxt_q, dec_nxt;
  logic [3:0]        bitcnt;
  logic [7:0]        sr, rx_byte, rd_q;
  logic              ack_q, dec_ack, first_q;
  logic [AW-1:0]     ptr;
  logic [PROG_W-1:0] prog_q;
  logic [HW_W-1:0]   hw_q;
  logic [6:0]        src_q, own;
  logic [AW:0]       clr_cnt;
  logic              clearing, rx_state, byte_end, wr_pulse, passive;

  assign own      = {prog_q, hw_q};
  assign rx_byte  = {sr[6:0], l_sda};
  assign clearing = (clr_cnt != CLR_END);
  assign passive  = (state == ST_WAITP);
  assign rx_state = state inside {ST_ADDR, ST_WDATA, ST_GCCMD, ST_GCPROG, ST_GCDATA};
  assign byte_end = rx_state && l_rise && (bitcnt == 4'd7);
  assign wr_pulse = byte_end && (state == ST_WDATA) && !first_q && !busy;

  i2c_gc_regfile #(.DEPTH(DEPTH), .WIDTH(8)) u_regs (
    .clk(clk),
    .we(clearing | wr_pulse),
    .waddr(clearing ? clr_cnt[AW-1:0] : ptr),
    .wdata(clearing ? 8'h00 : rx_byte),
    .raddr(ptr),
    .rdata(rd_q)
  );

  // acknowledge and follow-on state for a completed received byte
  always_comb begin
    dec_ack = 1'b0;
    dec_nxt = ST_HOLD;
    case (state)
      ST_ADDR: begin
        if (rx_byte == GC_ADDR_BYTE) begin
          dec_ack = GC_EN;
          dec_nxt = GC_EN ? ST_GCCMD : ST_WAITP;
        end else if (rx_byte == START_BYTE) begin
          dec_nxt = ST_HOLD;
        end else if (rx_byte[7:1] == CBUS_ADDR) begin
          dec_nxt = ST_WAITP;
        end else if (rx_byte[7:1] == own) begin
          dec_ack = !busy;
          dec_nxt = busy ? ST_HOLD : (rx_byte[0] ? ST_READ : ST_WDATA);
        end else begin
          dec_nxt = ST_WAITP;
        end
      end
      ST_WDATA: begin
        dec_ack = !busy;
        dec_nxt = busy ? ST_HOLD : ST_WDATA;
      end
      ST_GCCMD: begin
        if (rx_byte == GC_FULL_RST || rx_byte == GC_PIN_LOAD) begin
          dec_ack = 1'b1;
        end else if (rx_byte == GC_NEW_PROG) begin
          dec_ack = 1'b1;
          dec_nxt = ST_GCPROG;
        end else if (rx_byte[0]) begin
          dec_ack = 1'b1;
          dec_nxt = ST_GCDATA;
        end
      end
      ST_GCPROG, ST_GCDATA: dec_ack = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      nxt_q        <= ST_IDLE;
      bitcnt       <= '0;
      sr           <= '0;
      sda_oe       <= 1'b0;
      ack_q        <= 1'b0;
      first_q      <= 1'b0;
      ptr          <= '0;
      prog_q       <= PROG_RST;
      hw_q         <= hw_addr;
      src_q        <= '0;
      clr_cnt      <= '0;
      hwcall_src   <= '0;
      hwcall_data  <= '0;
      hwcall_valid <= 1'b0;
    end else begin
      hwcall_valid <= 1'b0;
      if (clearing) clr_cnt <= clr_cnt + 1'b1;

      if (l_stop) begin
        state  <= ST_IDLE;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (l_start && state != ST_WAITP) begin
        state  <= ST_ADDR;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (rx_state || state == ST_READ) begin
        if (state == ST_READ) begin
          if (l_rise && bitcnt < 4'd8) bitcnt <= bitcnt + 4'd1;
          if (l_fall && bitcnt >= 4'd1 && bitcnt <= 4'd7) begin
            sr     <= {sr[6:0], 1'b0};
            sda_oe <= ~sr[6];
          end
          if (l_fall && bitcnt == 4'd8) begin
            sda_oe <= 1'b0;
            bitcnt <= 4'd9;
            ptr    <= ptr + 1'b1;
          end
          if (l_rise && bitcnt == 4'd9) nxt_q <= l_sda ? ST_HOLD : ST_READ;
        end else begin
          if (l_rise && bitcnt < 4'd8) begin
            sr     <= rx_byte;
            bitcnt <= bitcnt + 4'd1;
          end
          if (l_fall && bitcnt == 4'd8) begin
            sda_oe <= ack_q;
            bitcnt <= 4'd9;
          end
          if (byte_end) begin
            ack_q <= dec_ack;
            nxt_q <= dec_nxt;
            case (state)
              ST_ADDR: first_q <= 1'b1;
              ST_WDATA: if (!busy) begin
                if (first_q) begin
                  ptr     <= rx_byte[AW-1:0];
                  first_q <= 1'b0;
                end else begin
                  ptr <= ptr + 1'b1;
                end
              end
              ST_GCCMD: begin
                if (rx_byte == GC_FULL_RST) begin
                  prog_q  <= PROG_RST;
                  hw_q    <= hw_addr;
                  ptr     <= '0;
                  clr_cnt <= '0;
                end else if (rx_byte == GC_PIN_LOAD) begin
                  hw_q <= hw_addr;
                end else if (rx_byte != GC_NEW_PROG && rx_byte[0]) begin
                  src_q <= rx_byte[7:1];
                end
              end
              ST_GCPROG: prog_q <= rx_byte[7 -: PROG_W];
              ST_GCDATA: begin
                hwcall_data  <= rx_byte;
                hwcall_src   <= src_q;
                hwcall_valid <= 1'b1;
              end
              default: ;
            endcase
          end
        end
        // end of the acknowledge clock: move on, load first read bit if needed
        if (l_fall && bitcnt == 4'd9) begin
          bitcnt <= '0;
          state  <= nxt_q;
          if (nxt_q == ST_READ) begin
            sr     <= rd_q;
            sda_oe <= ~rd_q[7];
          end else begin
            sda_oe <= 1'b0;
          end
        end
      end
    end
  end

endmodule

// File: rtl/i2c_gc_target_chk.sv
module i2c_gc_target_chk (
  input logic clk,
  input logic rst,
  input logic sda_oe,
  input logic hwcall_valid,
  input logic line_fall,
  input logic line_start,
  input logic line_stop,
  input logic passive
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!sda_oe && !hwcall_valid));

  // R1
  oe_timing_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> $past(line_fall || line_start || line_stop));

  // R3
  stop_release_chk: assert property (@(posedge clk) disable iff (rst)
    line_stop |=> !sda_oe);

  // R2
  passive_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    passive |-> !sda_oe);

  // R11
  call_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    hwcall_valid |=> !hwcall_valid);

endmodule

bind i2c_gc_target i2c_gc_target_chk u_chk (
  .clk(clk),
  .rst(rst),
  .sda_oe(sda_oe),
  .hwcall_valid(hwcall_valid),
  .line_fall(l_fall),
  .line_start(l_start),
  .line_stop(l_stop),
  .passive(passive)
);

// File: tb/i2c_gc_target_bench.sv
module i2c_gc_target_bench;

  localparam int Q = 6;
  localparam logic [3:0] PRST = 4'hA;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic m_sda = 1'b1;
  logic busy = 1'b0;
  logic [2:0] pins = 3'b011;
  logic sda_oe, hwcall_valid;
  logic [6:0] hwcall_src;
  logic [7:0] hwcall_data;
  logic sda_line;

  int checks = 0;
  int fails = 0;
  int oe_cnt = 0;
  int hv_cnt = 0;
  logic [6:0] cap_src = '0;
  logic [7:0] cap_data = '0;

  assign sda_line = m_sda & ~sda_oe;

  always #4 clk = ~clk;

  i2c_gc_target u_i2c_gc_target (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .busy(busy), .hw_addr(pins), .hwcall_src(hwcall_src),
    .hwcall_data(hwcall_data), .hwcall_valid(hwcall_valid)
  );

  always @(posedge clk) begin
    if (sda_oe) oe_cnt <= oe_cnt + 1;
    if (hwcall_valid) begin
      hv_cnt   <= hv_cnt + 1;
      cap_src  <= hwcall_src;
      cap_data <= hwcall_data;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic clk_bit(input logic b, output logic r);
    m_sda = b; wait_q();
    scl = 1'b1; wait_q();
    r = sda_line; wait_q();
    scl = 1'b0; wait_q();
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wait_q();
    scl = 1'b1; wait_q();
    m_sda = 1'b0; wait_q();
    scl = 1'b0; wait_q();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wait_q();
    scl = 1'b1; wait_q();
    m_sda = 1'b1; wait_q();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], r);
    clk_bit(1'b1, r);
    ack = !r;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, r);
      d[i] = r;
    end
    clk_bit(!mack, r);
  endtask

  // address probe: START, one byte, STOP; returns acknowledge
  task automatic probe(input logic [7:0] b, output logic ack);
    bus_start();
    send_byte(b, ack);
    bus_stop();
  endtask

  // set pointer then read one byte through a repeated START
  task automatic read_at(input logic [6:0] a, input logic [7:0] p, output logic [7:0] d);
    logic k;
    bus_start();
    send_byte({a, 1'b0}, k);
    send_byte(p, k);
    bus_start();
    send_byte({a, 1'b1}, k);
    recv_byte(1'b0, d);
    bus_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic a1, a2, k;
    logic [7:0] d;
    logic [6:0] own;
    int o0, h0;

    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (40) @(negedge clk);
    own = {PRST, pins};

    // R1 reset state
    chk("R1 reset sda_oe", sda_oe, 0);
    chk("R1 reset hwcall_valid", hwcall_valid, 0);

    // R1 R2 R8 R14 sweep of every write address, then a second byte
    for (int a = 0; a < 128; a++) begin
      bus_start();
      send_byte({a[6:0], 1'b0}, a1);
      send_byte({own, 1'b0}, a2);
      bus_stop();
      chk($sformatf("R1/R2 addr %0h ack", a), a1, (a[6:0] == own) || (a == 0));
      chk($sformatf("R2 addr %0h second ack", a), a2, (a[6:0] == own));
    end

    // R4 write with wrap, R5 combined read
    bus_start();
    send_byte({own, 1'b0}, k); chk("R4 addr ack", k, 1);
    send_byte(8'h0E, k);       chk("R4 ptr ack", k, 1);
    send_byte(8'h11, k);       chk("R4 d0 ack", k, 1);
    send_byte(8'h22, k);       chk("R4 d1 ack", k, 1);
    send_byte(8'h33, k);       chk("R4 d2 ack", k, 1);
    send_byte(8'h44, k);       chk("R4 d3 ack", k, 1);
    bus_stop();
    bus_start();
    send_byte({own, 1'b0}, k);
    send_byte(8'h0E, k);
    bus_start();
    send_byte({own, 1'b1}, k); chk("R5 read addr ack", k, 1);
    recv_byte(1'b1, d); chk("R5 read 14", d, 8'h11);
    recv_byte(1'b1, d); chk("R5 read 15", d, 8'h22);
    recv_byte(1'b0, d); chk("R4 read wrapped 0", d, 8'h33);
    // R6 after controller NACK the target is silent
    o0 = oe_cnt;
    recv_byte(1'b0, d);
    chk("R6 released data", d, 8'hFF);
    chk("R6 no drive", oe_cnt - o0, 0);
    bus_start();
    send_byte({own, 1'b1}, k); chk("R6 restart ack", k, 1);
    recv_byte(1'b0, d); chk("R6 resumes at 1", d, 8'h44);
    bus_stop();

    // R3 STOP part-way through a byte
    bus_start();
    send_byte({own, 1'b0}, k);
    send_byte(8'h05, k);
    for (int i = 0; i < 4; i++) clk_bit(1'b1, k);
    bus_stop();
    chk("R3 released after stop", sda_oe, 0);
    read_at(own, 8'h05, d);
    chk("R3 partial byte not stored", d, 8'h00);

    // R7 busy withholds acknowledge
    busy = 1'b1;
    probe({own, 1'b0}, k); chk("R7 busy addr nack", k, 0);
    busy = 1'b0;
    bus_start();
    send_byte({own, 1'b0}, k);
    send_byte(8'h03, k);
    busy = 1'b1;
    send_byte(8'h99, k); chk("R7 busy data nack", k, 0);
    busy = 1'b0;
    bus_stop();
    read_at(own, 8'h03, d); chk("R7 data not stored", d, 8'h00);

    // R9 reload pin part
    pins = 3'b101;
    bus_start();
    send_byte(8'h00, k); chk("R8 general call ack", k, 1);
    send_byte(8'h04, k); chk("R9 reload ack", k, 1);
    bus_stop();
    own = {PRST, pins};
    probe({own, 1'b0}, k); chk("R9 new address ack", k, 1);
    probe({PRST, 3'b011, 1'b0}, k); chk("R9 old address nack", k, 0);
    read_at(own, 8'h0E, d); chk("R9 registers kept", d, 8'h11);

    // R10 new programmable part
    bus_start();
    send_byte(8'h00, k);
    send_byte(8'h02, k); chk("R10 cmd ack", k, 1);
    send_byte(8'h60, k); chk("R10 value ack", k, 1);
    bus_stop();
    own = {4'h6, pins};
    probe({own, 1'b0}, k); chk("R10 new address ack", k, 1);
    probe({PRST, pins, 1'b0}, k); chk("R10 old address nack", k, 0);

    // R12 prohibited second byte
    bus_start();
    send_byte(8'h00, k);
    send_byte(8'h00, k); chk("R12 prohibited nack", k, 0);
    bus_stop();
    probe({own, 1'b0}, k); chk("R12 address unchanged", k, 1);

    // R11 hardware call
    h0 = hv_cnt;
    bus_start();
    send_byte(8'h00, k);
    send_byte({7'h2B, 1'b1}, k); chk("R11 call ack", k, 1);
    send_byte(8'hC3, k); chk("R11 data ack", k, 1);
    bus_stop();
    chk("R11 one strobe", hv_cnt - h0, 1);
    chk("R11 source", cap_src, 7'h2B);
    chk("R11 data", cap_data, 8'hC3);

    // R13 start byte
    o0 = oe_cnt;
    probe(8'h01, k); chk("R13 start byte nack", k, 0);
    chk("R13 no drive", oe_cnt - o0, 0);

    // R14 CBUS passive until STOP
    bus_start();
    send_byte(8'h03, k); chk("R14 cbus nack", k, 0);
    bus_start();
    send_byte({own, 1'b0}, k); chk("R14 passive ignores own", k, 0);
    bus_stop();
    probe({own, 1'b0}, k); chk("R14 active after stop", k, 1);

    // R8 full reset
    bus_start();
    send_byte(8'h00, k);
    send_byte(8'h06, k); chk("R8 reset ack", k, 1);
    bus_stop();
    repeat (40) @(negedge clk);
    own = {PRST, pins};
    probe({4'h6, pins, 1'b0}, k); chk("R8 programmed address gone", k, 0);
    read_at(own, 8'h0E, d); chk("R8 registers cleared", d, 8'h00);
    read_at(own, 8'h01, d); chk("R8 registers cleared 1", d, 8'h00);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule